// File: doc/BRIEF.md
# Fragment Batch Overlap Detector

This block sits in front of a memory controller's depth and color path and sorts a stream of z-buffered fragments into batches. While a batch is open, every accepted fragment issues a read request for its pixel at once and is recorded, with its payload, in a small fully associative store. When the batch closes, the block stops taking fragments and issues one write request per stored fragment, oldest first. It then empties the store in one cycle and opens a new batch. As a result, the reads of a batch never interleave with its writes, and no read of a later batch can overtake a write of an earlier one.

A batch closes for one of three reasons:
- the fragment at the input targets a pixel address that is already in the store;
- the store has just filled;
- the flush input is raised while the store holds at least one entry.

A fragment that collides with the store is held at the input, not discarded. It becomes the first member of the next batch. The depth comparison itself happens downstream, and the block passes the payload through unchanged.

Top module: `zbatch_sequencer`

## Requirements
- R1: After reset the store is empty, the block is collecting, `wr_valid` is 0, and `frag_ready` equals `rd_ready`.
- R2: While collecting, a fragment whose address misses the store and arrives with flush low is accepted in the cycle that `rd_ready` is high. The read request in that same cycle carries its address.
- R3: A valid fragment whose address equals a stored address is not accepted, and it closes the current batch.
- R4: The colliding fragment remains at the input. Its read is issued only after every write of the closed batch.
- R5: Accepting the DEPTH-th fragment of a batch (8 by default) closes the batch, so the next fragment waits until all its writes have drained.
- R6: Flush with a non-empty store closes the batch. Flush with an empty store produces no write. No fragment is accepted in a cycle where flush is high.
- R7: While draining, write requests carry the stored addresses and payloads in acceptance order. Each request is held until `wr_ready` completes it.
- R8: While draining, `rd_valid` and `frag_ready` are both 0.
- R9: After the last write of a batch, the store is empty, so an address from the drained batch is accepted again without another drain.
- R10: With `rd_ready` low, `frag_ready` is 0 and no fragment is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment present at the input |
| frag_ready | output | 1 | Fragment accepted when high together with frag_valid |
| frag_addr | input | AW (20) | Pixel address of the fragment |
| frag_data | input | DW (32) | Fragment payload (depth/color) |
| flush | input | 1 | Close the current batch if it is not empty |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | AW (20) | Pixel address to read |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request taken |
| wr_addr | output | AW (20) | Pixel address to write |
| wr_data | output | DW (32) | Payload to write |

## Verification
Two functions can meet in one cycle: a flush request and the arrival of a fragment. The bench raises both together on a non-empty batch. It judges the result by checking that `frag_ready` stays low in that cycle, and that the fragment's read appears only after every write of the flushed batch. Two closing causes can also coincide: a collision on the cycle after the store fills. The bench provokes this by sending the eighth distinct address and then a repeat of an earlier one. A reference model checks that only one drain takes place and that the repeat heads the next batch. Random backpressure on both request streams, with addresses drawn from a narrow range, makes these coincidences occur many more times.

// File: rtl/zb_pkg.sv
package zb_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } zb_state_e;

endpackage

// File: rtl/zb_store.sv
module zb_store #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          clr,
  input  logic [AW-1:0] probe_addr,
  output logic          hit,
  input  logic [IW-1:0] out_idx,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  logic [DEPTH-1:0] occ_q;
  logic [DEPTH-1:0] occ_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] match;

  // one comparator per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = occ_q[g] && (addr_q[g] == probe_addr);
  end

  assign hit = |match;

  always_comb begin
    occ_d = occ_q;
    if (clr) begin
      occ_d = '0;
    end else if (push) begin
      occ_d[push_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_d;
    end
  end

  // payload storage: enabled, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (push_idx == IW'(i))) begin
        addr_q[i] <= push_addr;
        data_q[i] <= push_data;
      end
    end
  end

  assign out_addr = addr_q[out_idx];
  assign out_data = data_q[out_idx];

  // R2: a batch never holds the same pixel twice
  a_r2_single_match : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R9: clearing empties every entry in one cycle
  a_r9_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ_q == '0));

endmodule

// File: rtl/zb_ctrl.sv
module zb_ctrl
  import zb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          hit,
  input  logic          flush,
  input  logic          rd_ready,
  input  logic          wr_ready,
  output logic          in_ready,
  output logic          rd_valid,
  output logic          push,
  output logic [IW-1:0] push_idx,
  output logic          wr_valid,
  output logic [IW-1:0] drain_idx,
  output logic          clr
);

  zb_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] dptr_q, dptr_d;
  logic          collecting;
  logic          blocked;
  logic          last_wr;
  logic          wr_fire;

  assign collecting = (st_q == ST_COLLECT);
  assign blocked    = flush || hit;
  assign rd_valid   = collecting && in_valid && !blocked;
  assign in_ready   = collecting && !blocked && rd_ready;
  assign push       = in_valid && in_ready;
  assign push_idx   = cnt_q[IW-1:0];
  assign wr_valid   = !collecting;
  assign wr_fire    = wr_valid && wr_ready;
  assign drain_idx  = dptr_q;
  assign last_wr    = (CW'(dptr_q) == (cnt_q - CW'(1)));
  assign clr        = wr_fire && last_wr;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    dptr_d = dptr_q;
    unique case (st_q)
      ST_COLLECT: begin
        if (flush && (cnt_q != '0)) begin
          st_d = ST_DRAIN;
        end else if (in_valid && hit && !flush) begin
          st_d = ST_DRAIN;
        end else if (push) begin
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == CW'(DEPTH - 1)) begin
            st_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (wr_fire) begin
          if (last_wr) begin
            st_d   = ST_COLLECT;
            cnt_d  = '0;
            dptr_d = '0;
          end else begin
            dptr_d = dptr_q + IW'(1);
          end
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_COLLECT;
      cnt_q  <= '0;
      dptr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      dptr_q <= dptr_d;
    end
  end

  // R8: draining shuts the input and the read stream
  a_r8_drain_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> (!rd_valid && !in_ready));

  // R5: occupancy never exceeds the store
  a_r5_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: filling the store closes the batch
  a_r5_full_closes : assert property (@(posedge clk) disable iff (!rst_n)
    (push && (cnt_q == CW'(DEPTH - 1))) |=> (st_q == ST_DRAIN));

  // R3: a collision closes the batch
  a_r3_hit_closes : assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && in_valid && hit && !flush) |=> (st_q == ST_DRAIN));

  // R6: flush on an empty store keeps collecting
  a_r6_empty_flush : assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && flush && (cnt_q == '0)) |=> (st_q == ST_COLLECT));

  // R7: a stalled write holds its slot
  a_r7_write_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(dptr_q)));

  // R9: last write returns to an empty, collecting state
  a_r9_reopen : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((st_q == ST_COLLECT) && (cnt_q == '0)));

endmodule

// File: rtl/zbatch_sequencer.sv
module zbatch_sequencer #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frag_valid,
  output logic          frag_ready,
  input  logic [AW-1:0] frag_addr,
  input  logic [DW-1:0] frag_data,
  input  logic          flush,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          hit;
  logic          push;
  logic          clr;
  logic [IW-1:0] push_idx;
  logic [IW-1:0] drain_idx;

  zb_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (frag_valid),
    .hit       (hit),
    .flush     (flush),
    .rd_ready  (rd_ready),
    .wr_ready  (wr_ready),
    .in_ready  (frag_ready),
    .rd_valid  (rd_valid),
    .push      (push),
    .push_idx  (push_idx),
    .wr_valid  (wr_valid),
    .drain_idx (drain_idx),
    .clr       (clr)
  );

  zb_store #(
    .AW    (AW),
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_idx   (push_idx),
    .push_addr  (frag_addr),
    .push_data  (frag_data),
    .clr        (clr),
    .probe_addr (frag_addr),
    .hit        (hit),
    .out_idx    (drain_idx),
    .out_addr   (wr_addr),
    .out_data   (wr_data)
  );

  assign rd_addr = frag_addr;

  // R10: no acceptance while the read stream stalls
  a_r10_rd_stall : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !frag_ready);

  // R8: the two request streams never overlap
  a_r8_streams_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R6: flush blocks acceptance
  a_r6_flush_blocks : assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !frag_ready);

endmodule

// File: tb/tb_zbatch_sequencer.sv
module tb_zbatch_sequencer;

  localparam int AW    = 20;
  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic          clk;
  logic          rst_n;
  logic          frag_valid;
  logic          frag_ready;
  logic [AW-1:0] frag_addr;
  logic [DW-1:0] frag_data;
  logic          flush;
  logic          rd_valid;
  logic          rd_ready;
  logic [AW-1:0] rd_addr;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  zbatch_sequencer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_addr(frag_addr), .frag_data(frag_data), .flush(flush),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rd_mode = 0;   // 0 always ready, 1 random, 2 stalled
  int wr_mode = 0;   // 0 always ready, 1 random
  int wr_seen = 0;
  int wr_total = 0;

  // reference model state
  logic [AW-1:0] mb_addr [$];
  logic [DW-1:0] mb_data [$];
  logic [AW-1:0] xr_addr [$];
  int            xr_before [$];
  logic [AW-1:0] xw_addr [$];
  logic [DW-1:0] xw_data [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_close();
    foreach (mb_addr[i]) begin
      xw_addr.push_back(mb_addr[i]);
      xw_data.push_back(mb_data[i]);
    end
    wr_total += mb_addr.size();
    mb_addr.delete();
    mb_data.delete();
  endfunction

  function automatic void model_accept(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit found = 1'b0;
    foreach (mb_addr[i]) if (mb_addr[i] == a) found = 1'b1;
    if (found) model_close();           // R3/R4: collision closes, fragment heads next batch
    mb_addr.push_back(a);
    mb_data.push_back(d);
    xr_addr.push_back(a);
    xr_before.push_back(wr_total);
    if (mb_addr.size() == DEPTH) model_close();  // R5
  endfunction

  // ready generators, updated 1 ns after each edge
  always @(posedge clk) begin
    #1;
    rd_ready <= (rd_mode == 0) ? 1'b1 : (rd_mode == 2) ? 1'b0 : (($urandom % 4) != 0);
    wr_ready <= (wr_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  // monitor: 1 ns before each rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      cycles++;
      if (wr_valid) begin
        check(!frag_ready && !rd_valid, "R8", {frag_ready, rd_valid}, 0);
      end
      if (rd_valid && rd_ready) begin
        if (xr_addr.size() == 0) begin
          check(1'b0, "R2 unexpected read", rd_addr, 0);
        end else begin
          logic [AW-1:0] ea;
          int eb;
          ea = xr_addr.pop_front();
          eb = xr_before.pop_front();
          check(rd_addr == ea, "R2 read address", rd_addr, ea);
          check(wr_seen == eb, "R4 writes before read", wr_seen, eb);
        end
      end
      if (wr_valid && wr_ready) begin
        if (xw_addr.size() == 0) begin
          check(1'b0, "R7 unexpected write", wr_addr, 0);
        end else begin
          logic [AW-1:0] wa;
          logic [DW-1:0] wd;
          wa = xw_addr.pop_front();
          wd = xw_data.pop_front();
          check(wr_addr == wa, "R7 write address", wr_addr, wa);
          check(wr_data == wd, "R7 write data", wr_data, wd);
        end
        wr_seen++;
      end
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // driver: called at posedge+1, returns at posedge+1
  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_flush);
    if (with_flush) begin
      if (mb_addr.size() != 0) model_close();
    end
    model_accept(a, d);
    frag_valid = 1'b1;
    frag_addr  = a;
    frag_data  = d;
    flush      = with_flush;
    if (with_flush) begin
      #1;
      check(frag_ready == 1'b0, "R6 flush blocks fragment", frag_ready, 0);
      @(posedge clk); #1;
      flush = 1'b0;
    end
    forever begin
      #1;
      if (frag_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    frag_valid = 1'b0;
  endtask

  task automatic do_flush();
    if (mb_addr.size() != 0) model_close();
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (xr_addr.size() == 0 && xw_addr.size() == 0) break;
      @(posedge clk); #1;
    end
    check(xr_addr.size() == 0 && xw_addr.size() == 0, "R7 all requests seen",
          xr_addr.size() + xw_addr.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    frag_valid = 1'b0;
    frag_addr = '0;
    frag_data = '0;
    flush = 1'b0;
    rd_ready = 1'b1;
    wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    #1;
    // R1: reset state
    check(wr_valid == 1'b0, "R1 wr_valid after reset", wr_valid, 0);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    check(frag_ready == rd_ready, "R1 ready after reset", frag_ready, rd_ready);
    @(posedge clk); #1;

    // R2/R7/R6: three fragments, then flush
    send(20'h00010, 32'hA0000001, 1'b0);
    send(20'h00020, 32'hA0000002, 1'b0);
    send(20'h00030, 32'hA0000003, 1'b0);
    do_flush();
    wait_idle();

    // R6: flush on an empty store produces no write
    do_flush();
    for (int i = 0; i < 4; i++) begin
      #1;
      check(wr_valid == 1'b0, "R6 empty flush", wr_valid, 0);
      @(posedge clk); #1;
    end

    // R3/R4: collision on 0x00011
    send(20'h00010, 32'hB0000001, 1'b0);
    send(20'h00011, 32'hB0000002, 1'b0);
    send(20'h00012, 32'hB0000003, 1'b0);
    send(20'h00011, 32'hB0000004, 1'b0);
    do_flush();
    wait_idle();

    // R5: fill the store, then a collision right after filling
    for (int i = 0; i < DEPTH; i++) send(AW'(32'h100 + i), 32'hC0000000 + i, 1'b0);
    send(20'h00100, 32'hC00000FF, 1'b0);
    send(20'h00100, 32'hC00000FE, 1'b0);
    do_flush();
    wait_idle();

    // R6: flush and fragment in the same cycle
    send(20'h00200, 32'hD0000001, 1'b0);
    send(20'h00201, 32'hD0000002, 1'b0);
    send(20'h00202, 32'hD0000003, 1'b1);
    // R9: address of the drained batch is accepted with no further drain
    send(20'h00200, 32'hD0000004, 1'b0);
    do_flush();
    wait_idle();

    // R10: stalled read stream blocks the input
    rd_mode = 2;
    @(posedge clk); #1;
    frag_valid = 1'b1;
    frag_addr  = 20'h00300;
    frag_data  = 32'hE0000001;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(frag_ready == 1'b0, "R10 stalled read", frag_ready, 0);
      @(posedge clk); #1;
    end
    frag_valid = 1'b0;
    rd_mode = 0;
    @(posedge clk); #1;
    send(20'h00300, 32'hE0000001, 1'b0);
    do_flush();
    wait_idle();

    // stress: narrow address range, random backpressure on both streams
    rd_mode = 1;
    wr_mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 12);
      send(a, $urandom, (($urandom % 16) == 0));
      if (($urandom % 32) == 0) do_flush();
    end
    do_flush();
    wait_idle();
    check(wr_seen == wr_total, "R7 write count", wr_seen, wr_total);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule